// File: doc/BRIEF.md
# Iterative Square-Root Unit (one root bit per cycle)

This unit returns the integer square root of an unsigned radicand that is `2*ROOT_W` bits wide. The result is `ROOT_W` bits wide. It is meant for the mantissa path of a floating-point square root: the caller gives it a normalized mantissa and gets back the truncated root. The caller handles exponent halving, packing and special operands.

A radicand enters through a valid/ready handshake. After acceptance the unit runs a non-restoring recurrence over three registers: a signed two's-complement partial remainder, a partial root, and a weight register. The weight register starts at 2^(2·ROOT_W) and is shifted right by two places on every iteration. On each iteration the sign of the remainder selects whether the partial root term is added or subtracted. No restoring step is taken. After `ROOT_W` iterations, one correction cycle subtracts one from the root if the remainder ended negative. The unit then pulses `out_valid`.

Back-pressure: the input side stalls the producer by holding `in_ready` low for the whole computation. The output side has no ready. The result is presented with a single-cycle `out_valid` and stays on `out_root`/`out_rem_neg` until the next result replaces it. A consumer that needs the value later can read it at any time before then.

Top module: `nr_sqrt`

## Requirements
- R1: While reset is asserted and immediately after it, `in_ready` is 1, `out_valid` is 0, `out_root` is 0 and `out_rem_neg` is 0.
- R2: A radicand is accepted only on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the cycle after acceptance until the result appears. An `in_valid` raised while `in_ready` is 0 is ignored, and its radicand does not affect the result in progress.
- R3: `out_valid` rises exactly `ROOT_W+1` clock edges after the accepting edge. `in_ready` is 1 again in that same cycle, so a new radicand can be accepted on the very next edge.
- R4: For every radicand X from 1 to 2^(2·ROOT_W)−1, `out_root` equals floor(sqrt(X)).
- R5: `out_rem_neg` is the sign of the partial remainder after the last iteration, before correction. Equivalently, it is 1 exactly when the returned root is even.
- R6: `out_valid` is high for exactly one cycle per accepted radicand.
- R7: `out_root` and `out_rem_neg` change only in a cycle where `out_valid` is 1. Otherwise they hold their previous values.
- R8: The boundary radicands give these roots: 1 gives 1, all ones gives 2^ROOT_W−1, a perfect square s² gives s, and s²−1 gives s−1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Radicand offered |
| in_ready | output | 1 | Unit idle; radicand will be taken |
| in_radicand | input | 2*ROOT_W | Unsigned radicand |
| out_valid | output | 1 | One-cycle result strobe |
| out_root | output | ROOT_W | Floor square root, held until the next result |
| out_rem_neg | output | 1 | Sign of final remainder before correction |

## Verification
The bench builds two copies of the unit. The first uses `ROOT_W=4`, with 8-bit radicands, and sweeps all 255 legal radicands. This exhausts every path through the add/subtract decision and the final correction. The second uses `ROOT_W=24`, with 48-bit radicands shaped like a mantissa. It exercises the guard bits of the remainder and the full weight-shift distance with boundary values (1, all ones, squares of 2^23 and of 2^24−1, and their neighbours) and with random radicands. In both copies the bench holds `in_valid` high back-to-back, leaves idle gaps, and raises spurious requests while the unit is busy.

// File: rtl/nr_sqrt_pkg.sv
package nr_sqrt_pkg;

  // sequencing phases of one root computation
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_ITER = 2'd1,
    SQ_FIX  = 2'd2
  } sq_phase_e;

  // remainder width: radicand width plus two guard bits (sign and carry headroom)
  function automatic int rem_bits(int root_w);
    return 2 * root_w + 2;
  endfunction

  // partial root and weight width: weight starts at 2^(2*root_w)
  function automatic int part_bits(int root_w);
    return 2 * root_w + 1;
  endfunction

endpackage

// File: rtl/nr_sqrt_seq.sv
module nr_sqrt_seq
  import nr_sqrt_pkg::*;
#(
  parameter int ROOT_W = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  output logic idle,
  output logic step_en,
  output logic fix_en
);

  localparam int CW = $clog2(ROOT_W + 1);
  localparam logic [CW-1:0] LAST_STEP = CW'(ROOT_W - 1);

  sq_phase_e       phase_q;
  logic [CW-1:0]   step_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= SQ_IDLE;
      step_q  <= '0;
    end else begin
      unique case (phase_q)
        SQ_IDLE: begin
          if (accept) begin
            phase_q <= SQ_ITER;
            step_q  <= '0;
          end
        end
        SQ_ITER: begin
          step_q <= step_q + 1'b1;
          if (step_q == LAST_STEP) phase_q <= SQ_FIX;
        end
        SQ_FIX:  phase_q <= SQ_IDLE;
        default: phase_q <= SQ_IDLE;
      endcase
    end
  end

  assign idle    = (phase_q == SQ_IDLE);
  assign step_en = (phase_q == SQ_ITER);
  assign fix_en  = (phase_q == SQ_FIX);

endmodule

// File: rtl/nr_sqrt_step.sv
module nr_sqrt_step
  import nr_sqrt_pkg::*;
#(
  parameter int ROOT_W = 24
) (
  input  logic signed [rem_bits(ROOT_W)-1:0]  rem_i,
  input  logic        [part_bits(ROOT_W)-1:0] part_i,
  input  logic        [part_bits(ROOT_W)-1:0] wgt_i,
  output logic signed [rem_bits(ROOT_W)-1:0]  rem_o,
  output logic        [part_bits(ROOT_W)-1:0] part_o,
  output logic        [part_bits(ROOT_W)-1:0] wgt_o
);

  localparam int RW = rem_bits(ROOT_W);
  localparam int PW = part_bits(ROOT_W);

  logic              rem_neg;
  logic [PW-1:0]     wgt_cur;
  logic [PW-1:0]     wgt_dbl;
  logic [PW-1:0]     part_up;
  logic [PW-1:0]     part_dn;
  logic signed [RW-1:0] part_s;
  logic signed [RW-1:0] wgt_s;

  // weight for this iteration is the stored one divided by four
  assign wgt_cur = wgt_i >> 2;
  assign wgt_dbl = wgt_cur << 1;
  assign rem_neg = rem_i[RW-1];

  assign part_s = $signed({1'b0, part_i});
  assign wgt_s  = $signed({1'b0, wgt_cur});

  assign part_up = part_i + wgt_dbl;
  assign part_dn = part_i - wgt_dbl;

  always_comb begin
    if (rem_neg) begin
      rem_o  = rem_i + part_s - wgt_s;
      part_o = part_dn >> 1;
    end else begin
      rem_o  = rem_i - part_s - wgt_s;
      part_o = part_up >> 1;
    end
    wgt_o = wgt_cur;
  end

endmodule

// File: rtl/nr_sqrt_fix.sv
module nr_sqrt_fix #(
  parameter int ROOT_W = 24
) (
  input  logic [ROOT_W-1:0] odd_root_i,
  input  logic              rem_neg_i,
  output logic [ROOT_W-1:0] root_o
);

  // non-restoring digits leave an odd root that may sit one above the floor
  always_comb begin
    if (rem_neg_i) root_o = odd_root_i - 1'b1;
    else           root_o = odd_root_i;
  end

endmodule

// File: rtl/nr_sqrt.sv
module nr_sqrt
  import nr_sqrt_pkg::*;
#(
  parameter int ROOT_W = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [2*ROOT_W-1:0]   in_radicand,
  output logic                  out_valid,
  output logic [ROOT_W-1:0]     out_root,
  output logic                  out_rem_neg
);

  localparam int XW = 2 * ROOT_W;
  localparam int RW = rem_bits(ROOT_W);
  localparam int PW = part_bits(ROOT_W);
  localparam logic [PW-1:0] WGT_INIT = {1'b1, {XW{1'b0}}};

  logic                 idle;
  logic                 step_en;
  logic                 fix_en;
  logic                 accept;

  logic signed [RW-1:0] rem_q;
  logic signed [RW-1:0] rem_nx;
  logic [PW-1:0]        part_q;
  logic [PW-1:0]        part_nx;
  logic [PW-1:0]        wgt_q;
  logic [PW-1:0]        wgt_nx;
  logic [ROOT_W-1:0]    root_fixed;

  assign accept   = in_valid & idle;
  assign in_ready = idle;

  nr_sqrt_seq #(.ROOT_W(ROOT_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .idle    (idle),
    .step_en (step_en),
    .fix_en  (fix_en)
  );

  nr_sqrt_step #(.ROOT_W(ROOT_W)) u_step (
    .rem_i  (rem_q),
    .part_i (part_q),
    .wgt_i  (wgt_q),
    .rem_o  (rem_nx),
    .part_o (part_nx),
    .wgt_o  (wgt_nx)
  );

  nr_sqrt_fix #(.ROOT_W(ROOT_W)) u_fix (
    .odd_root_i (part_q[ROOT_W-1:0]),
    .rem_neg_i  (rem_q[RW-1]),
    .root_o     (root_fixed)
  );

  // recurrence registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      part_q <= '0;
      wgt_q  <= '0;
    end else if (accept) begin
      rem_q  <= $signed({2'b00, in_radicand});
      part_q <= '0;
      wgt_q  <= WGT_INIT;
    end else if (step_en) begin
      rem_q  <= rem_nx;
      part_q <= part_nx;
      wgt_q  <= wgt_nx;
    end
  end

  // result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_root    <= '0;
      out_rem_neg <= 1'b0;
    end else begin
      out_valid <= fix_en;
      if (fix_en) begin
        out_root    <= root_fixed;
        out_rem_neg <= rem_q[RW-1];
      end
    end
  end

endmodule

// File: rtl/nr_sqrt_chk.sv
module nr_sqrt_chk #(
  parameter int ROOT_W = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic [2*ROOT_W-1:0] in_radicand,
  input logic                out_valid,
  input logic [ROOT_W-1:0]   out_root,
  input logic                out_rem_neg
);

  localparam int XW = 2 * ROOT_W;
  localparam int EW = XW + 2;

  logic [XW-1:0] held_x;
  int            lat_q;
  logic [EW-1:0] r_e;
  logic [EW-1:0] r_sq;
  logic [EW-1:0] r1_sq;
  logic [EW-1:0] x_e;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_x <= '0;
      lat_q  <= 0;
    end else if (in_valid && in_ready) begin
      held_x <= in_radicand;
      lat_q  <= 0;
    end else if (!in_ready) begin
      lat_q  <= lat_q + 1;
    end
  end

  assign r_e   = EW'(out_root);
  assign r_sq  = r_e * r_e;
  assign r1_sq = (r_e + EW'(1)) * (r_e + EW'(1));
  assign x_e   = EW'(held_x);

  assert_busy_refuse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (in_ready && lat_q == ROOT_W + 1));

  assert_floor_root_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (r_sq <= x_e && r1_sq > x_e));

  assert_sign_parity_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_rem_neg == ~out_root[0]));

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_root) && $stable(out_rem_neg)));

endmodule

bind nr_sqrt nr_sqrt_chk #(.ROOT_W(ROOT_W)) u_chk (.*);

// File: tb/nr_sqrt_bench.sv
`timescale 1ns/1ps

module nr_sqrt_lane #(
  parameter int K       = 4,
  parameter bit EXHAUST = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  output int   n_chk,
  output int   n_bad,
  output logic fin
);

  localparam int XW = 2 * K;

  logic          in_valid;
  logic          in_ready;
  logic [XW-1:0] in_radicand;
  logic          out_valid;
  logic [K-1:0]  out_root;
  logic          out_rem_neg;

  nr_sqrt #(.ROOT_W(K)) u_nr_sqrt (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_radicand (in_radicand),
    .out_valid   (out_valid),
    .out_root    (out_root),
    .out_rem_neg (out_rem_neg)
  );

  longint unsigned vecs[$];
  bit              edge_case[$];

  function automatic longint unsigned isqrt(longint unsigned x);
    longint unsigned r = 0;
    for (int b = K - 1; b >= 0; b--) begin
      longint unsigned t = r | (64'd1 << b);
      if (t * t <= x) r = t;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s (K=%0d) actual=%0h expected=%0h", tag, K, act, exp);
    end
  endtask

  task automatic add_vec(input longint unsigned v, input bit edge_flag);
    longint unsigned mask = (64'd1 << XW) - 1;
    if (v != 0 && v <= mask) begin
      vecs.push_back(v);
      edge_case.push_back(edge_flag);
    end
  endtask

  initial begin
    longint unsigned mask;
    longint unsigned cur;
    longint unsigned e_root;
    bit   cur_edge;
    bit   e_neg;
    bit   e_done;
    int   cnt;
    int   idx;
    int   gap;
    int   tail;
    mask = (64'd1 << XW) - 1;
    n_chk = 0; n_bad = 0; fin = 1'b0;
    in_valid = 1'b0; in_radicand = '0;
    cur = 0; cur_edge = 1'b0; e_root = 0; e_neg = 1'b0; e_done = 1'b0;
    cnt = 0; idx = 0; gap = 0; tail = 0;

    if (EXHAUST) begin
      for (longint unsigned v = 1; v <= mask; v++) add_vec(v, 1'b1);
    end else begin
      longint unsigned roots[8];
      roots[0] = 2; roots[1] = 3; roots[2] = 255; roots[3] = 256;
      roots[4] = 4095; roots[5] = 64'd1 << (K - 1); roots[6] = (64'd1 << K) - 1;
      roots[7] = 1000003;
      add_vec(1, 1'b1); add_vec(2, 1'b1); add_vec(3, 1'b1);
      add_vec(mask, 1'b1); add_vec(mask - 1, 1'b1);
      foreach (roots[i]) begin
        add_vec(roots[i] * roots[i], 1'b1);
        add_vec(roots[i] * roots[i] - 1, 1'b1);
        add_vec(roots[i] * roots[i] + 1, 1'b1);
      end
      for (int i = 0; i < 40; i++) begin
        longint unsigned rv = {$urandom(), $urandom()};
        rv = rv & mask;
        if (rv == 0) rv = 1;
        add_vec(rv, 1'b0);
      end
    end

    // R1: values while reset is held
    @(negedge clk);
    chk("R1 in_ready in reset", in_ready, 1);
    chk("R1 out_valid in reset", out_valid, 0);
    chk("R1 out_root in reset", out_root, 0);
    chk("R1 out_rem_neg in reset", out_rem_neg, 0);
    while (!rst_n) @(negedge clk);

    forever begin
      // compare outputs against the model state for this cycle
      chk("R2 in_ready", in_ready, (cnt == 0));
      if (e_done) chk("R3 out_valid latency", out_valid, 1);
      else        chk("R6 out_valid single pulse", out_valid, 0);
      if (e_done) begin
        chk(cur_edge ? "R8 boundary root" : "R4 floor root", out_root, e_root);
        chk("R5 remainder sign", out_rem_neg, e_neg);
      end else begin
        chk("R7 root held", out_root, e_root);
        chk("R7 sign held", out_rem_neg, e_neg);
      end

      if (idx == vecs.size() && cnt == 0 && !e_done) begin
        tail++;
        if (tail == 3) break;
      end

      // drive the next input
      if (cnt == 0) begin
        if (idx < vecs.size() && gap == 0) begin
          in_valid    = 1'b1;
          in_radicand = vecs[idx][XW-1:0];
        end else begin
          in_valid = 1'b0;
          if (gap > 0) gap--;
        end
      end else begin
        // R2: spurious requests while busy must be ignored
        in_valid    = (cnt % 2 == 1);
        in_radicand = XW'({$urandom(), $urandom()});
      end

      // advance the model across the coming edge
      e_done = 1'b0;
      if (in_valid && cnt == 0) begin
        cur      = vecs[idx];
        cur_edge = edge_case[idx];
        cnt      = K + 1;
        idx++;
        gap      = idx % 3;
      end else if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          e_done = 1'b1;
          e_root = isqrt(cur);
          e_neg  = ~e_root[0];
        end
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    fin = 1'b1;
  end

endmodule

module nr_sqrt_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   c_s, f_s, c_w, f_w;
  logic fin_s, fin_w;

  always #2.5 clk = ~clk;

  nr_sqrt_lane #(.K(4),  .EXHAUST(1'b1)) u_lane_small (
    .clk(clk), .rst_n(rst_n), .n_chk(c_s), .n_bad(f_s), .fin(fin_s)
  );

  nr_sqrt_lane #(.K(24), .EXHAUST(1'b0)) u_lane_wide (
    .clk(clk), .rst_n(rst_n), .n_chk(c_w), .n_bad(f_w), .fin(fin_w)
  );

  initial begin
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  end

  initial begin
    int cyc = 0;
    int total;
    int failed;
    while (!(fin_s === 1'b1 && fin_w === 1'b1) && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    @(negedge clk);
    total  = c_s + c_w;
    failed = f_s + f_w;
    if (!(fin_s === 1'b1 && fin_w === 1'b1)) begin
      total++;
      failed++;
      $display("FAIL R3 watchdog: run did not complete, actual=hung expected=done");
    end
    $display("[TB] %0d tests run, %0d failed", total, failed);
    $finish;
  end

endmodule